// File: doc/BRIEF.md
# SD Host Data Port with Block Counter

This block is the CPU-facing data window of an SD-style card host. One 32-bit data access from the CPU becomes four byte transfers with the card. A read collects four bytes into one word. A write sends the four bytes of a word out one at a time. Each byte transfer uses a valid/ready handshake. While the four bytes are moving, the CPU access is held off by a wait signal.

The block counts the bytes inside a 512-byte block. At each block boundary it can decrement a 16-bit block count. That count sits in the upper half of a size/count register, which software loads. When the count runs out, a programmable completion delay starts. When the delay expires, the block signals data-end and, if the current command asked for it, requests an automatic stop command. Single-block read and write commands end at their first block boundary, whether or not counting is enabled.

The block keeps two status flags, data-available and space-available. It also produces one-cycle event pulses that an interrupt controller next to it collects. Software writes the command register through a strobe. The block keeps the command index, two mode bits, and whether the command came right after an application-command prefix.

Top module: `sd_data_port`

## Requirements
- R1: In both directions, the first card byte of an access maps to word bits 7:0 and the fourth byte maps to bits 31:24.
- R2: Every completed data access adds 4 to a byte counter. The 128th access after the counter was last cleared is the block boundary, and the counter then returns to 0.
- R3: At a block boundary with count-enable set, bits 31:16 of the size/count register decrease by one and bits 15:0 keep their value. With count-enable clear, the register does not change.
- R4: When a boundary takes the count from 1 to 0, `ev_data_end` pulses exactly DONE_DELAY cycles after that access completes, and not before. In the same cycle `stop_req` pulses, but only if the auto-stop bit was set with the command.
- R5: On a read, the boundary that takes the count to zero clears data-available.
- R6: A completed read sets data-available. If the flag is still set after the other rules below have been applied, `ev_data_avail` pulses.
- R7: With command index 17 (read) or 24 (write), and no prefix, the boundary immediately pulses `ev_data_end`. It also clears that direction's available flag and suppresses that direction's available event.
- R8: If the previous command had index 55 (application prefix), indices 17 and 24 get no single-block treatment.
- R9: If `card_more` is low when a read completes, data-available clears and `ev_data_end` pulses in the same cycle.
- R10: A completed write sets space-available and pulses `ev_space_avail`, unless R7 applies.
- R11: A command strobe clears both flags and resets the byte counter.
- R12: After reset, the flags, events, wait and size/count register are all zero. `dat_wait` rises only after an accepted request and stays high until the fourth byte handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_idx | input | 6 | Command index written with the strobe |
| cmd_cnt_en | input | 1 | Block count enable for this command |
| cmd_auto_stop | input | 1 | Request an automatic stop after the last block |
| szc_wr | input | 1 | Size/count register write strobe |
| szc_wdata | input | 32 | Size/count write value (count in 31:16) |
| szc_rdata | output | 32 | Current size/count register |
| dat_req | input | 1 | Start a data access (taken when not waiting) |
| dat_we | input | 1 | Access direction, 1 = write to card |
| dat_wdata | input | 32 | Write word |
| dat_rdata | output | 32 | Last word read from the card |
| dat_wait | output | 1 | Access in progress |
| card_rd_valid | input | 1 | Card offers a byte |
| card_rd_data | input | 8 | Byte from card |
| card_rd_ready | output | 1 | Port accepts a card byte |
| card_more | input | 1 | Card still has data after this word |
| card_wr_valid | output | 1 | Port offers a byte to card |
| card_wr_data | output | 8 | Byte to card |
| card_wr_ready | input | 1 | Card accepts the byte |
| data_avail | output | 1 | Data-available flag |
| space_avail | output | 1 | Space-available flag |
| ev_data_end | output | 1 | Data-end event pulse |
| ev_data_avail | output | 1 | Data-available event pulse |
| ev_space_avail | output | 1 | Space-available event pulse |
| stop_req | output | 1 | Automatic stop command request pulse |

## Verification
A byte counter out of phase with the block moves the boundary, so the count decrement, the single-block data-end or the last-block delay shows up on a different access than the 128th. That shows on the first boundary after the fault. A lane index that is off scrambles the order of the bytes in `dat_rdata` or on `card_wr_data` on the very first access. A completion timer that is wrong shows as a data-end pulse one or more cycles early or late relative to the final access. A command latch that is wrong shows as single-block or auto-stop behaviour on the wrong commands at the next boundary.

// File: rtl/sd_dp_pkg.sv
// Shared constants for the SD host data port.
// Assumes 6-bit command indices as used by SD-style cards.
package sd_dp_pkg;
    localparam logic [5:0] CMD_SINGLE_RD = 6'd17;
    localparam logic [5:0] CMD_SINGLE_WR = 6'd24;
    localparam logic [5:0] CMD_APP_PFX   = 6'd55;

    typedef struct packed {
        logic [5:0] idx;
        logic       cnt_en;
        logic       auto_stop;
        logic       after_app;
    } cmd_ctx_t;
endpackage

// File: rtl/sd_dp_lane.sv
// Byte lane engine: splits one CPU word into BYTES card byte handshakes,
// or gathers BYTES card bytes into one word. Lane 0 moves first.
// Assumes BYTES >= 2 and that start is ignored while busy.
module sd_dp_lane #(
    parameter int BYTES = 4,
    localparam int WORD_W = BYTES * 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic              busy,
    output logic              busy_we,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    input  logic              rd_valid,
    input  logic [7:0]        rd_byte,
    output logic              rd_ready,
    output logic              wr_valid,
    output logic [7:0]        wr_byte,
    input  logic              wr_ready
);
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] wbuf;
    logic              hs;

    assign rd_ready = busy && !busy_we;
    assign wr_valid = busy && busy_we;
    assign wr_byte  = wbuf[lane*8 +: 8];
    assign hs       = (rd_ready && rd_valid) || (wr_valid && wr_ready);
    assign done     = hs && (lane == LANE_W'(BYTES - 1));

    // Track the access in flight and the lane being moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            busy_we <= 1'b0;
            lane    <= '0;
            wbuf    <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                busy_we <= we;
                lane    <= '0;
                wbuf    <= wdata;
            end
        end else if (hs) begin
            lane <= lane + 1'b1;
            if (done) busy <= 1'b0;
        end
    end

    // One capture register per byte lane of the read word.
    for (genvar g = 0; g < BYTES; g++) begin : g_rd_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata[g*8 +: 8] <= 8'h00;
            else if (rd_ready && rd_valid && lane == LANE_W'(g))
                rdata[g*8 +: 8] <= rd_byte;
        end
    end
endmodule

// File: rtl/sd_dp_blkcnt.sv
// Byte position within a block and the size/count register.
// Upper CNT_W bits hold the block count, lower CNT_W bits are kept as loaded.
// Assumes BLOCK_BYTES is a multiple of STEP.
module sd_dp_blkcnt #(
    parameter int BLOCK_BYTES = 512,
    parameter int STEP = 4,
    parameter int CNT_W = 16,
    localparam int BW = $clog2(BLOCK_BYTES),
    localparam int SZ_W = 2 * CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic            cnt_en,
    input  logic            ld,
    input  logic [SZ_W-1:0] ld_data,
    output logic [SZ_W-1:0] szc,
    output logic            boundary,
    output logic            last_blk
);
    logic [BW-1:0] bpos;

    assign boundary = step && (bpos == BW'(BLOCK_BYTES - STEP));
    assign last_blk = boundary && cnt_en && (szc[SZ_W-1:CNT_W] == CNT_W'(1));

    // Advance the byte position and wrap it at the block size.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            bpos <= '0;
        else if (step)
            bpos <= boundary ? '0 : bpos + BW'(STEP);
    end

    // Load the size/count register or count one block down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            szc <= '0;
        else if (ld)
            szc <= ld_data;
        else if (boundary && cnt_en)
            szc[SZ_W-1:CNT_W] <= szc[SZ_W-1:CNT_W] - 1'b1;
    end
endmodule

// File: rtl/sd_dp_timer.sv
// Completion delay: fire pulses DELAY cycles after start.
// Assumes DELAY >= 1; a restart reloads the delay.
module sd_dp_timer #(
    parameter int DELAY = 8,
    localparam int TW = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fire
);
    logic [TW-1:0] rem;

    // Count the delay down and pulse when it runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (start)
                rem <= TW'(DELAY);
            else if (rem != '0) begin
                rem <= rem - 1'b1;
                if (rem == TW'(1)) fire <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sd_data_port.sv
// SD host data port: CPU word accesses to card byte streams, block
// counting, completion delay, available flags and event pulses.
// Assumes the CPU does not strobe a command while an access is in flight.
module sd_data_port
    import sd_dp_pkg::*;
#(
    parameter int BYTES = 4,
    parameter int BLOCK_BYTES = 512,
    parameter int CNT_W = 16,
    parameter int DONE_DELAY = 8,
    localparam int WORD_W = BYTES * 8,
    localparam int SZ_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [5:0]        cmd_idx,
    input  logic              cmd_cnt_en,
    input  logic              cmd_auto_stop,
    input  logic              szc_wr,
    input  logic [SZ_W-1:0]   szc_wdata,
    output logic [SZ_W-1:0]   szc_rdata,
    input  logic              dat_req,
    input  logic              dat_we,
    input  logic [WORD_W-1:0] dat_wdata,
    output logic [WORD_W-1:0] dat_rdata,
    output logic              dat_wait,
    input  logic              card_rd_valid,
    input  logic [7:0]        card_rd_data,
    output logic              card_rd_ready,
    input  logic              card_more,
    output logic              card_wr_valid,
    output logic [7:0]        card_wr_data,
    input  logic              card_wr_ready,
    output logic              data_avail,
    output logic              space_avail,
    output logic              ev_data_end,
    output logic              ev_data_avail,
    output logic              ev_space_avail,
    output logic              stop_req
);
    cmd_ctx_t ctx;
    logic     app_pending;
    logic     busy, busy_we, acc_done;
    logic     blk_bound, blk_last;
    logic     tmr_fire;
    logic     de_q, st_q;
    logic     da_n, sa_n, de_n, st_n, eda_n, esa_n;

    sd_dp_lane #(.BYTES(BYTES)) lane_i (
        .clk(clk), .rst_n(rst_n),
        .start(dat_req), .we(dat_we), .wdata(dat_wdata),
        .busy(busy), .busy_we(busy_we), .done(acc_done), .rdata(dat_rdata),
        .rd_valid(card_rd_valid), .rd_byte(card_rd_data), .rd_ready(card_rd_ready),
        .wr_valid(card_wr_valid), .wr_byte(card_wr_data), .wr_ready(card_wr_ready)
    );

    sd_dp_blkcnt #(.BLOCK_BYTES(BLOCK_BYTES), .STEP(BYTES), .CNT_W(CNT_W)) blk_i (
        .clk(clk), .rst_n(rst_n),
        .clear(cmd_wr), .step(acc_done && !cmd_wr), .cnt_en(ctx.cnt_en),
        .ld(szc_wr), .ld_data(szc_wdata), .szc(szc_rdata),
        .boundary(blk_bound), .last_blk(blk_last)
    );

    // Pick a delayed or same-cycle completion.
    if (DONE_DELAY > 0) begin : g_delay
        sd_dp_timer #(.DELAY(DONE_DELAY)) tmr_i (
            .clk(clk), .rst_n(rst_n), .start(blk_last), .fire(tmr_fire)
        );
    end else begin : g_nodelay
        assign tmr_fire = 1'b0;
    end

    assign dat_wait       = busy;
    assign ev_data_end    = de_q || tmr_fire;
    assign stop_req       = st_q || (tmr_fire && ctx.auto_stop);

    // Work out the flags and events of the completing access.
    always_comb begin
        da_n  = data_avail;
        sa_n  = space_avail;
        de_n  = 1'b0;
        st_n  = 1'b0;
        eda_n = 1'b0;
        esa_n = 1'b0;
        if (acc_done) begin
            if (!busy_we) begin
                da_n = 1'b1;
                if (blk_last) da_n = 1'b0;
                if (blk_bound && !ctx.after_app && ctx.idx == CMD_SINGLE_RD) begin
                    da_n = 1'b0;
                    de_n = 1'b1;
                end
                if (!card_more) begin
                    da_n = 1'b0;
                    de_n = 1'b1;
                end
                eda_n = da_n;
            end else begin
                sa_n = 1'b1;
                if (blk_bound && !ctx.after_app && ctx.idx == CMD_SINGLE_WR) begin
                    sa_n = 1'b0;
                    de_n = 1'b1;
                end
                esa_n = sa_n;
            end
            if (blk_last && DONE_DELAY == 0) begin
                de_n = 1'b1;
                st_n = ctx.auto_stop;
            end
        end
        if (cmd_wr) begin
            da_n  = 1'b0;
            sa_n  = 1'b0;
            de_n  = 1'b0;
            st_n  = 1'b0;
            eda_n = 1'b0;
            esa_n = 1'b0;
        end
    end

    // Register flags and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_avail     <= 1'b0;
            space_avail    <= 1'b0;
            de_q           <= 1'b0;
            st_q           <= 1'b0;
            ev_data_avail  <= 1'b0;
            ev_space_avail <= 1'b0;
        end else begin
            data_avail     <= da_n;
            space_avail    <= sa_n;
            de_q           <= de_n;
            st_q           <= st_n;
            ev_data_avail  <= eda_n;
            ev_space_avail <= esa_n;
        end
    end

    // Latch the command context and the application prefix history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx         <= '0;
            app_pending <= 1'b0;
        end else if (cmd_wr) begin
            ctx.idx       <= cmd_idx;
            ctx.cnt_en    <= cmd_cnt_en;
            ctx.auto_stop <= cmd_auto_stop;
            ctx.after_app <= app_pending;
            app_pending   <= (cmd_idx == CMD_APP_PFX);
        end
    end
endmodule

// File: rtl/sd_dp_chk.sv
// Protocol checks on the port boundary of the SD host data port.
module sd_dp_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_wr,
    input logic dat_req,
    input logic dat_wait,
    input logic card_rd_ready,
    input logic card_wr_valid,
    input logic data_avail,
    input logic space_avail,
    input logic ev_data_end,
    input logic ev_data_avail,
    input logic ev_space_avail,
    input logic stop_req
);
    // R12
    wait_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_wait) |-> $past(dat_req));
    // R12
    card_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rd_ready || card_wr_valid) |-> dat_wait);
    // R1
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_rd_ready && card_wr_valid));
    // R11
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (!data_avail && !space_avail));
    // R6
    avail_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_data_avail |-> data_avail);
    // R10
    space_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_space_avail |-> space_avail);
    // R4
    stop_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> ev_data_end);
endmodule

bind sd_data_port sd_dp_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_req(dat_req),
    .dat_wait(dat_wait), .card_rd_ready(card_rd_ready),
    .card_wr_valid(card_wr_valid), .data_avail(data_avail),
    .space_avail(space_avail), .ev_data_end(ev_data_end),
    .ev_data_avail(ev_data_avail), .ev_space_avail(ev_space_avail),
    .stop_req(stop_req)
);

// File: tb/sd_data_port_tb_top.sv
module sd_data_port_tb_top;
    localparam int DLY = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic        cmd_cnt_en = 1'b0;
    logic        cmd_auto_stop = 1'b0;
    logic        szc_wr = 1'b0;
    logic [31:0] szc_wdata = '0;
    logic [31:0] szc_rdata;
    logic        dat_req = 1'b0;
    logic        dat_we = 1'b0;
    logic [31:0] dat_wdata = '0;
    logic [31:0] dat_rdata;
    logic        dat_wait;
    logic        card_rd_valid = 1'b1;
    logic [7:0]  card_rd_data;
    logic        card_rd_ready;
    logic        card_more = 1'b1;
    logic        card_wr_valid;
    logic [7:0]  card_wr_data;
    logic        card_wr_ready = 1'b1;
    logic        data_avail, space_avail, ev_data_end, ev_data_avail, ev_space_avail, stop_req;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [7:0] rd_seq = 8'h10;
    logic [7:0] exp_seq = 8'h10;
    logic [7:0] wr_log [4];
    int         wr_n = 0;
    int         rd_bad = 0;

    // sampled at completion of the last access
    logic [31:0] g_rdata, g_szc;
    logic g_de, g_da, g_sa, g_eda, g_esa, g_stop;

    always #10 clk = ~clk;

    sd_data_port #(.DONE_DELAY(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_idx(cmd_idx),
        .cmd_cnt_en(cmd_cnt_en), .cmd_auto_stop(cmd_auto_stop),
        .szc_wr(szc_wr), .szc_wdata(szc_wdata), .szc_rdata(szc_rdata),
        .dat_req(dat_req), .dat_we(dat_we), .dat_wdata(dat_wdata),
        .dat_rdata(dat_rdata), .dat_wait(dat_wait),
        .card_rd_valid(card_rd_valid), .card_rd_data(card_rd_data),
        .card_rd_ready(card_rd_ready), .card_more(card_more),
        .card_wr_valid(card_wr_valid), .card_wr_data(card_wr_data),
        .card_wr_ready(card_wr_ready), .data_avail(data_avail),
        .space_avail(space_avail), .ev_data_end(ev_data_end),
        .ev_data_avail(ev_data_avail), .ev_space_avail(ev_space_avail),
        .stop_req(stop_req)
    );

    // card model: byte source and sink
    assign card_rd_data = rd_seq;
    always @(posedge clk) begin
        if (card_rd_valid && card_rd_ready) rd_seq <= rd_seq + 8'd1;
        if (card_wr_valid && card_wr_ready) begin
            wr_log[wr_n % 4] <= card_wr_data;
            wr_n <= wr_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cmd(input logic [5:0] idx, input logic cen, input logic ast);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_idx = idx; cmd_cnt_en = cen; cmd_auto_stop = ast;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic load_szc(input logic [31:0] v);
        @(negedge clk);
        szc_wr = 1'b1; szc_wdata = v;
        @(negedge clk);
        szc_wr = 1'b0;
    endtask

    // one data access; returns at the negedge where its results are visible
    task automatic access(input logic we, input logic [31:0] wd);
        @(negedge clk);
        dat_req = 1'b1; dat_we = we; dat_wdata = wd;
        @(negedge clk);
        dat_req = 1'b0;
        if (!dat_wait) begin
            n_chk++; n_err++;
            $display("FAIL R12 wait not raised: got 0 expected 1");
        end
        while (dat_wait) @(negedge clk);
        g_rdata = dat_rdata; g_szc = szc_rdata; g_de = ev_data_end;
        g_da = data_avail; g_sa = space_avail; g_eda = ev_data_avail;
        g_esa = ev_space_avail; g_stop = stop_req;
        if (!we) begin
            if (dat_rdata !== {exp_seq + 8'd3, exp_seq + 8'd2, exp_seq + 8'd1, exp_seq}) rd_bad++;
            exp_seq = exp_seq + 8'd4;
        end
    endtask

    // n reads; counts data-end pulses seen before the last
    task automatic reads(input int n, output int early_de);
        early_de = 0;
        for (int i = 0; i < n; i++) begin
            access(1'b0, 32'h0);
            if (i < n - 1 && g_de) early_de++;
        end
    endtask

    task automatic t_reset;
        chk("R12", "wait after reset", {31'd0, dat_wait}, 32'd0);
        chk("R12", "flags after reset", {30'd0, data_avail, space_avail}, 32'd0);
        chk("R12", "size/count after reset", szc_rdata, 32'd0);
        chk("R12", "events after reset", {28'd0, ev_data_end, ev_data_avail, ev_space_avail, stop_req}, 32'd0);
    endtask

    task automatic t_read_order;
        cmd(6'd18, 1'b0, 1'b0);
        access(1'b0, 32'h0);
        chk("R1", "read word byte order", g_rdata, 32'h13121110);
        chk("R6", "data-avail flag and event", {30'd0, g_da, g_eda}, 32'd3);
    endtask

    task automatic t_write;
        int e;
        cmd(6'd25, 1'b0, 1'b0);
        access(1'b1, 32'hA1B2C3D4);
        chk("R1", "write byte order", {wr_log[3], wr_log[2], wr_log[1], wr_log[0]}, 32'hA1B2C3D4);
        chk("R10", "space flag and event", {30'd0, g_sa, g_esa}, 32'd3);
        cmd(6'd24, 1'b0, 1'b0);
        e = 0;
        for (int i = 0; i < 128; i++) begin
            access(1'b1, 32'h01020304);
            if (i < 127 && (g_de || !g_esa)) e++;
        end
        chk("R10", "writes before single-write boundary", e, 0);
        chk("R7", "single write end: data-end, space, space event", {29'd0, g_de, g_sa, g_esa}, 32'd4);
    endtask

    task automatic t_count;
        int e;
        load_szc(32'h0003_0200);
        cmd(6'd18, 1'b1, 1'b1);
        reads(127, e);
        chk("R2", "count before boundary", g_szc, 32'h0003_0200);
        access(1'b0, 32'h0);
        chk("R3", "count after first block", g_szc, 32'h0002_0200);
        chk("R3", "no data-end on middle block", {31'd0, g_de}, 32'd0);
        reads(256, e);
        chk("R3", "count after last block", g_szc, 32'h0000_0200);
        chk("R5", "data-avail cleared on last block", {31'd0, g_da}, 32'd0);
        chk("R4", "data-end early", {30'd0, g_de, g_stop}, 32'd0);
        e = 0;
        for (int i = 1; i < DLY; i++) begin
            @(negedge clk);
            if (ev_data_end || stop_req) e++;
        end
        chk("R4", "data-end before delay", e, 0);
        @(negedge clk);
        chk("R4", "data-end and stop after delay", {30'd0, ev_data_end, stop_req}, 32'd3);
        @(negedge clk);
        chk("R4", "data-end is one pulse", {31'd0, ev_data_end}, 32'd0);
    endtask

    task automatic t_no_auto;
        int e;
        load_szc(32'h0001_0040);
        cmd(6'd18, 1'b1, 1'b0);
        reads(128, e);
        repeat (DLY) @(negedge clk);
        chk("R4", "data-end without stop", {30'd0, ev_data_end, stop_req}, 32'd2);
    endtask

    task automatic t_cnt_off;
        int e;
        load_szc(32'h0005_0200);
        cmd(6'd18, 1'b0, 1'b1);
        reads(128, e);
        chk("R3", "count unchanged with enable clear", g_szc, 32'h0005_0200);
        chk("R3", "no data-end, flag kept", {30'd0, g_de, g_eda}, 32'd1);
    endtask

    task automatic t_single_rd;
        int e;
        cmd(6'd55, 1'b0, 1'b0);
        cmd(6'd17, 1'b0, 1'b0);
        reads(128, e);
        chk("R8", "prefixed index 17 boundary", {29'd0, g_de, g_da, g_eda}, 32'd3);
        cmd(6'd17, 1'b0, 1'b0);
        reads(128, e);
        chk("R7", "data-end before single-read boundary", e, 0);
        chk("R7", "single read end: data-end, flag, event", {29'd0, g_de, g_da, g_eda}, 32'd4);
    endtask

    task automatic t_no_more;
        cmd(6'd18, 1'b0, 1'b0);
        access(1'b0, 32'h0);
        card_more = 1'b0;
        access(1'b0, 32'h0);
        chk("R9", "card empty: data-end, flag, event", {29'd0, g_de, g_da, g_eda}, 32'd4);
        card_more = 1'b1;
    endtask

    task automatic t_cmd_clear;
        int e;
        load_szc(32'h0002_0011);
        cmd(6'd18, 1'b1, 1'b0);
        reads(10, e);
        cmd(6'd25, 1'b0, 1'b0);
        access(1'b1, 32'h0);
        chk("R11", "space set before command", {31'd0, g_sa}, 32'd1);
        cmd(6'd18, 1'b1, 1'b0);
        chk("R11", "flags after command", {30'd0, data_avail, space_avail}, 32'd0);
        reads(127, e);
        chk("R11", "byte counter restarted", g_szc, 32'h0002_0011);
        access(1'b0, 32'h0);
        chk("R2", "boundary on 128th access", g_szc, 32'h0001_0011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_order();
        t_write();
        t_count();
        t_no_auto();
        t_cnt_off();
        t_single_rd();
        t_no_more();
        t_cmd_clear();
        chk("R1", "read words with bad byte order", rd_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule